// File: doc/BRIEF.md
# Early-Late Code Timing Discriminator

This block measures how far a received spread-spectrum signal sits from the local code in time. The received I and Q samples arrive at four samples per chip. Each sample is multiplied by two copies of the fastest code in the stack. One copy leads the punctual timing by half a chip and the other lags it by half a chip. The two products are summed over a programmable number of samples. At the end of each integration period, each branch's I and Q sums are squared and added. The block then outputs the early energy minus the late energy as a saturated signed error word, together with a one-cycle strobe.

The error word is meant to be sent to a distant transmitter, which moves its own code timing to correct the error. The slower codes stacked under the fast code have chips four times longer and play no part here. A programmable energy floor detects that the signal has gone: when both energies are below it, the error is forced to zero and a lock-loss flag is raised. A clear input restarts the block between calls, so one instance can be handed to a new call once the previous one has settled.

Top module: `eld_discriminator`

## Requirements
- R1: Reset (synchronous, active low) drives `err_out` to 0, `err_valid` to 0 and `lock_lost` to 0. It clears both accumulators, the sample count and the code history. A cleared history entry counts as code value 0.
- R2: The code is antipodal: code bit 1 means +1 and code bit 0 means -1. The early reference is the `code_in` bit presented with the current accepted sample. The late reference is the `code_in` bit presented with the accepted sample four positions earlier, which spans one chip. Each branch adds reference×I into its I sum and reference×Q into its Q sum.
- R3: An integration period spans `int_len` accepted samples, and a value of 0 acts as 1. `int_len` is captured at reset, at clear and at each period end. A change part-way through a period therefore applies from the following period. With a length of 1, periods run back to back with one strobe per sample.
- R4: Cycles with `samp_valid` low change neither the sums, nor the count, nor the code history.
- R5: The error word is (early I² + early Q²) − (late I² + late Q²). If the last sample of a period is accepted at clock edge k, `err_valid` is high for exactly one cycle, from edge k+2 to edge k+3.
- R6: The error word saturates to the signed range of `err_out`: +32767 and −32768 at the default width.
- R7: When both energies are strictly below `energy_floor`, the strobe carries `err_out` = 0 and `lock_lost` = 1. Otherwise it carries the computed error with `lock_lost` = 0.
- R8: `err_out` and `lock_lost` hold their values between strobes.
- R9: `chan_clear` discards the current partial period, including a sample presented in the same cycle, even when that sample would end the period. It emits no strobe for the discarded period. It empties the code history and restarts the count with the current `int_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_valid | input | 1 | Sample qualifier, high for each quarter-chip sample |
| samp_i | input | SAMP_W (8) | In-phase sample, signed |
| samp_q | input | SAMP_W (8) | Quadrature sample, signed |
| code_in | input | 1 | Local fast-code bit at the early timing, paired with the sample |
| int_len | input | INT_W (10) | Integration length in accepted samples |
| energy_floor | input | EN_W (37) | Energy threshold for lock-loss detection |
| chan_clear | input | 1 | Restart for call reassignment |
| err_out | output | OUT_W (16) | Saturated signed timing error |
| err_valid | output | 1 | One-cycle strobe for a new error word |
| lock_lost | output | 1 | Both energies below the floor on the last strobe |

## Verification
Two functions can land on the same clock edge. The first is the end of a period, where the final sample is folded into the dumped sums while the accumulators restart. The second is a clear, which must cancel that period end.

The bench provokes the first case with an integration length of 1, so every accepted sample ends a period and starts the next. It checks that each strobe matches a per-sample energy model. The second case is provoked by asserting `chan_clear` together with the sample that would complete a period. It is judged by the absence of any strobe and by a following full period whose result matches a model that has restarted from an empty code history.

// File: rtl/eld_pkg.sv
// Shared constants and types for the early-late discriminator.
// Assumes quarter-chip sampling of the fastest code.
package eld_pkg;
    localparam int SAMPLES_PER_CHIP  = 4;
    localparam int HALF_CHIP_SAMPLES = SAMPLES_PER_CHIP / 2;
    localparam int NUM_BRANCHES      = 2;

    typedef enum int {
        BR_EARLY = 0,
        BR_LATE  = 1
    } branch_e;
endpackage

// File: rtl/eld_code_taps.sv
// Code tap line: produces the early and late reference bits.
// The early tap is the incoming code bit. The late tap is the bit presented
// SPAN accepted samples earlier (one chip at quarter-chip sampling).
// Assumes the caller masks adv while clr is high.
module eld_code_taps #(
    parameter int SPAN = 2 * eld_pkg::HALF_CHIP_SAMPLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic code_in,
    output logic ref_early,
    output logic ref_late
);
    logic [SPAN-1:0] hist_q;

    // Shift the code history once per accepted sample; empty it on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hist_q <= '0;
        end else if (adv) begin
            hist_q <= {hist_q[SPAN-2:0], code_in};
        end
    end

    assign ref_early = code_in;
    assign ref_late  = hist_q[SPAN-1];
endmodule

// File: rtl/eld_accum.sv
// One correlator branch: accumulates +/-I and +/-Q against a single reference
// bit, and dumps the final sums at the period end.
// Assumes ACC_W is wide enough for the longest period, so the sums never wrap.
module eld_accum #(
    parameter int SAMP_W = 8,
    parameter int ACC_W  = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     adv,
    input  logic                     fin,
    input  logic                     ref_pos,
    input  logic signed [SAMP_W-1:0] samp_i,
    input  logic signed [SAMP_W-1:0] samp_q,
    output logic signed [ACC_W-1:0]  dump_i,
    output logic signed [ACC_W-1:0]  dump_q
);
    localparam int EXT = ACC_W - SAMP_W;

    logic signed [ACC_W-1:0] ext_i, ext_q, term_i, term_q, acc_i, acc_q;

    assign ext_i  = {{EXT{samp_i[SAMP_W-1]}}, samp_i};
    assign ext_q  = {{EXT{samp_q[SAMP_W-1]}}, samp_q};
    assign term_i = ref_pos ? ext_i : -ext_i;
    assign term_q = ref_pos ? ext_q : -ext_q;

    // Running sums; restart at each period end, reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_i <= '0;
            acc_q <= '0;
        end else if (adv) begin
            acc_i <= fin ? '0 : acc_i + term_i;
            acc_q <= fin ? '0 : acc_q + term_q;
        end
    end

    // Capture the completed sums, including the final sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dump_i <= '0;
            dump_q <= '0;
        end else if (adv && fin) begin
            dump_i <= acc_i + term_i;
            dump_q <= acc_q + term_q;
        end
    end
endmodule

// File: rtl/eld_energy_diff.sv
// Two-stage back end: squares the dumped sums into two energies, then forms the
// saturated early-minus-late difference with the energy-floor test.
// Assumes dump_v is a one-cycle pulse that marks new sums.
module eld_energy_diff #(
    parameter int ACC_W = 18,
    parameter int OUT_W = 16,
    localparam int EN_W = 2 * ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dump_v,
    input  logic signed [ACC_W-1:0] e_i,
    input  logic signed [ACC_W-1:0] e_q,
    input  logic signed [ACC_W-1:0] l_i,
    input  logic signed [ACC_W-1:0] l_q,
    input  logic [EN_W-1:0]         energy_floor,
    output logic signed [OUT_W-1:0] err_out,
    output logic                    err_valid,
    output logic                    lock_lost
);
    localparam logic signed [EN_W:0] MAXV = {{(EN_W - OUT_W + 2){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [EN_W:0] MINV = ~MAXV;

    logic signed [2*ACC_W-1:0] sq_ei, sq_eq, sq_li, sq_lq;
    logic [EN_W-1:0]           en_e_d, en_l_d, en_e_q, en_l_q;
    logic                      en_v;
    logic signed [EN_W:0]      diff;
    logic signed [OUT_W-1:0]   sat;

    assign sq_ei  = e_i * e_i;
    assign sq_eq  = e_q * e_q;
    assign sq_li  = l_i * l_i;
    assign sq_lq  = l_q * l_q;
    assign en_e_d = {1'b0, sq_ei} + {1'b0, sq_eq};
    assign en_l_d = {1'b0, sq_li} + {1'b0, sq_lq};

    // Energy stage: register both branch energies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_e_q <= '0;
            en_l_q <= '0;
            en_v   <= 1'b0;
        end else begin
            en_v <= dump_v;
            if (dump_v) begin
                en_e_q <= en_e_d;
                en_l_q <= en_l_d;
            end
        end
    end

    assign diff = $signed({1'b0, en_e_q}) - $signed({1'b0, en_l_q});

    // Clamp the difference to the output range.
    always_comb begin
        if (diff > MAXV)      sat = {1'b0, {(OUT_W-1){1'b1}}};
        else if (diff < MINV) sat = {1'b1, {(OUT_W-1){1'b0}}};
        else                  sat = diff[OUT_W-1:0];
    end

    // Output stage: publish the error or the lock-loss result, held until the next strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_out   <= '0;
            lock_lost <= 1'b0;
            err_valid <= 1'b0;
        end else begin
            err_valid <= en_v;
            if (en_v) begin
                if (en_e_q < energy_floor && en_l_q < energy_floor) begin
                    err_out   <= '0;
                    lock_lost <= 1'b1;
                end else begin
                    err_out   <= sat;
                    lock_lost <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/eld_discriminator.sv
// Top level of the early-late timing discriminator. Counts accepted samples per
// integration period, drives the two correlator branches from the code taps,
// and passes the dumped sums to the energy/difference back end.
// Assumes code_in carries the fast code at the early timing, paired with each sample.
module eld_discriminator #(
    parameter int SAMP_W = 8,
    parameter int INT_W  = 10,
    parameter int OUT_W  = 16,
    localparam int ACC_W = SAMP_W + INT_W,
    localparam int EN_W  = 2 * ACC_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     samp_valid,
    input  logic signed [SAMP_W-1:0] samp_i,
    input  logic signed [SAMP_W-1:0] samp_q,
    input  logic                     code_in,
    input  logic [INT_W-1:0]         int_len,
    input  logic [EN_W-1:0]          energy_floor,
    input  logic                     chan_clear,
    output logic signed [OUT_W-1:0]  err_out,
    output logic                     err_valid,
    output logic                     lock_lost
);
    import eld_pkg::*;

    logic [INT_W-1:0] cnt_q, len_q, eff_len;
    logic             adv, last, fin, dump_v;
    logic [NUM_BRANCHES-1:0] ref_pos;
    logic signed [ACC_W-1:0] dump_i [NUM_BRANCHES];
    logic signed [ACC_W-1:0] dump_q [NUM_BRANCHES];

    assign adv     = samp_valid & ~chan_clear;
    assign eff_len = (len_q == '0) ? INT_W'(1) : len_q;
    assign last    = (cnt_q == eff_len - INT_W'(1));
    assign fin     = adv & last;

    // Sample counter and length capture at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_clear) begin
            cnt_q <= '0;
            len_q <= int_len;
        end else if (adv) begin
            if (last) begin
                cnt_q <= '0;
                len_q <= int_len;
            end else begin
                cnt_q <= cnt_q + INT_W'(1);
            end
        end
    end

    // Mark the cycle in which dumped sums are fresh.
    always_ff @(posedge clk) begin
        if (!rst_n) dump_v <= 1'b0;
        else        dump_v <= fin;
    end

    eld_code_taps #(.SPAN(2 * HALF_CHIP_SAMPLES)) u_taps (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (chan_clear),
        .adv       (adv),
        .code_in   (code_in),
        .ref_early (ref_pos[BR_EARLY]),
        .ref_late  (ref_pos[BR_LATE])
    );

    for (genvar b = 0; b < NUM_BRANCHES; b++) begin : g_branch
        eld_accum #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (chan_clear),
            .adv     (adv),
            .fin     (fin),
            .ref_pos (ref_pos[b]),
            .samp_i  (samp_i),
            .samp_q  (samp_q),
            .dump_i  (dump_i[b]),
            .dump_q  (dump_q[b])
        );
    end

    eld_energy_diff #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_diff (
        .clk          (clk),
        .rst_n        (rst_n),
        .dump_v       (dump_v),
        .e_i          (dump_i[BR_EARLY]),
        .e_q          (dump_q[BR_EARLY]),
        .l_i          (dump_i[BR_LATE]),
        .l_q          (dump_q[BR_LATE]),
        .energy_floor (energy_floor),
        .err_out      (err_out),
        .err_valid    (err_valid),
        .lock_lost    (lock_lost)
    );
endmodule

// File: rtl/eld_discriminator_chk.sv
// Property checker for eld_discriminator, attached by bind below.
// Assumes reset is held for at least two cycles at start-up.
module eld_discriminator_chk #(
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    fin,
    input logic                    err_valid,
    input logic signed [OUT_W-1:0] err_out,
    input logic                    lock_lost
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!err_valid && err_out == '0 && !lock_lost));

    // R5
    strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(fin, 3));

    // R7
    lock_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && lock_lost) |-> err_out == '0);

    // R8
    output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> ($stable(err_out) && $stable(lock_lost)));
endmodule

bind eld_discriminator eld_discriminator_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin       (fin),
    .err_valid (err_valid),
    .err_out   (err_out),
    .lock_lost (lock_lost)
);

// File: tb/eld_discriminator_tb_top.sv
module eld_discriminator_tb_top;
    localparam int SAMP_W = 8;
    localparam int INT_W  = 10;
    localparam int OUT_W  = 16;
    localparam int EN_W   = 2 * (SAMP_W + INT_W) + 1;

    typedef struct packed {
        int     len;
        int     amp_i;
        int     amp_q;
        int     dly;
        int     gap;
        longint flr;
        int     exp_lock;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{16,  20,  10, 0, 0, 64'd0,      0},
        '{16,  20,  10, 4, 3, 64'd0,      0},
        '{16,  20,  10, 2, 0, 64'd0,      0},
        '{64, 100, -80, 0, 0, 64'd0,      0},
        '{8,    2,   1, 0, 0, 64'd100000, 1},
        '{8,    2,   1, 0, 2, 64'd200,    0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic samp_valid = 1'b0;
    logic signed [SAMP_W-1:0] samp_i = '0;
    logic signed [SAMP_W-1:0] samp_q = '0;
    logic code_in = 1'b0;
    logic [INT_W-1:0] int_len = '0;
    logic [EN_W-1:0] energy_floor = '0;
    logic chan_clear = 1'b0;
    logic signed [OUT_W-1:0] err_out;
    logic err_valid, lock_lost;

    always #4 clk = ~clk;

    eld_discriminator #(.SAMP_W(SAMP_W), .INT_W(INT_W), .OUT_W(OUT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_i(samp_i),
        .samp_q(samp_q), .code_in(code_in), .int_len(int_len),
        .energy_floor(energy_floor), .chan_clear(chan_clear),
        .err_out(err_out), .err_valid(err_valid), .lock_lost(lock_lost)
    );

    int n_checks = 0;
    int n_fail = 0;
    int n_res = 0;
    int n_exp = 0;
    int n_cmp = 0;
    longint res_err [512];
    int     res_lock [512];
    longint exp_err [512];
    int     exp_lock [512];

    // Model state built from the requirements.
    int     m_hist [4];
    longint m_ei, m_eq, m_li, m_lq;
    int     m_cnt, m_len;
    int     gidx = 100;

    task automatic chk(input string req, input longint act, input longint expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Capture every strobe.
    always @(negedge clk) begin
        if (rst_n && err_valid) begin
            res_err[n_res]  = err_out;
            res_lock[n_res] = lock_lost;
            n_res++;
        end
    end

    function automatic bit pn(input int k);
        logic [15:0] x;
        x = 16'(k * 40503) ^ 16'h5A5A;
        return ^(x & 16'hB4C1);
    endfunction

    task automatic m_clear(input int len);
        for (int k = 0; k < 4; k++) m_hist[k] = 0;
        m_ei = 0; m_eq = 0; m_li = 0; m_lq = 0;
        m_cnt = 0;
        m_len = len;
    endtask

    // R2/R3/R5/R6/R7 model of one accepted sample.
    task automatic m_step(input int si, input int sq, input bit c);
        int se, sl, eff;
        longint e, l, d;
        se = c ? 1 : -1;
        sl = (m_hist[3] != 0) ? 1 : -1;
        m_ei += se * si; m_eq += se * sq;
        m_li += sl * si; m_lq += sl * sq;
        for (int k = 3; k > 0; k--) m_hist[k] = m_hist[k-1];
        m_hist[0] = c;
        m_cnt++;
        eff = (m_len == 0) ? 1 : m_len;
        if (m_cnt == eff) begin
            e = m_ei * m_ei + m_eq * m_eq;
            l = m_li * m_li + m_lq * m_lq;
            if (e < longint'(energy_floor) && l < longint'(energy_floor)) begin
                exp_err[n_exp] = 0; exp_lock[n_exp] = 1;
            end else begin
                d = e - l;
                if (d > 32767) d = 32767;
                if (d < -32768) d = -32768;
                exp_err[n_exp] = d; exp_lock[n_exp] = 0;
            end
            n_exp++;
            m_ei = 0; m_eq = 0; m_li = 0; m_lq = 0;
            m_cnt = 0;
            m_len = int_len;
        end
    endtask

    task automatic send(input int si, input int sq, input bit c);
        samp_valid = 1'b1;
        samp_i = SAMP_W'(si);
        samp_q = SAMP_W'(sq);
        code_in = c;
        m_step(si, sq, c);
        @(negedge clk);
        samp_valid = 1'b0;
    endtask

    task automatic send_gen(input int ai, input int aq, input int dly);
        bit c, r;
        c = pn(gidx >>> 2);
        r = pn((gidx - dly) >>> 2);
        send(r ? ai : -ai, r ? aq : -aq, c);
        gidx++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            samp_valid = 1'b0;
            samp_i = 8'sd127;
            samp_q = -8'sd128;
            code_in = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic do_clear(input int len);
        int_len = INT_W'(len);
        samp_valid = 1'b0;
        chan_clear = 1'b1;
        @(negedge clk);
        chan_clear = 1'b0;
        m_clear(len);
    endtask

    task automatic compare_new(input string tag);
        chk({tag, " strobe count"}, n_res, n_exp);
        while (n_cmp < n_exp && n_cmp < n_res) begin
            chk({tag, " R5 error word"}, res_err[n_cmp], exp_err[n_cmp]);
            chk({tag, " R7 lock flag"}, res_lock[n_cmp], exp_lock[n_cmp]);
            n_cmp++;
        end
        n_cmp = n_exp;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lat;
        int base;
        m_clear(0);
        int_len = 10'd4;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        m_clear(4);
        // R1 reset state
        chk("R1 err_out", err_out, 0);
        chk("R1 err_valid", err_valid, 0);
        chk("R1 lock_lost", lock_lost, 0);

        // Table walk: R2, R4, R5, R6, R7 across alignments, gaps, floors
        for (int v = 0; v < NVEC; v++) begin
            energy_floor = EN_W'(VECS[v].flr);
            do_clear(VECS[v].len);
            for (int k = 0; k < VECS[v].len; k++) begin
                send_gen(VECS[v].amp_i, VECS[v].amp_q, VECS[v].dly);
                if (VECS[v].gap != 0 && (k % VECS[v].gap) == VECS[v].gap - 1) idle(2);
            end
            idle(6);
            compare_new($sformatf("vec%0d R2 R4", v));
            chk($sformatf("vec%0d R7 table lock", v), res_lock[n_res-1], VECS[v].exp_lock);
            // R8 hold between strobes
            idle(10);
            chk("R8 err_out held", err_out, res_err[n_res-1]);
            chk("R8 lock_lost held", lock_lost, res_lock[n_res-1]);
        end
        energy_floor = '0;

        // R6 saturation reached by the full-alignment vector
        chk("R6 positive clamp", res_err[3], 32767);

        // R5 latency: strobe in the third cycle after the last accepted sample
        do_clear(4);
        for (int k = 0; k < 3; k++) send_gen(30, 5, 0);
        send_gen(30, 5, 0);
        lat = 1;
        while (!err_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk("R5 strobe latency", lat, 3);
        @(negedge clk);
        chk("R5 one-cycle strobe", err_valid, 0);
        idle(4);
        compare_new("R5 latency");

        // R3 length 1: back-to-back periods, boundary every sample
        do_clear(1);
        base = n_res;
        for (int k = 0; k < 6; k++) send_gen(40, 7, 1);
        idle(6);
        chk("R3 len1 strobes", n_res - base, 6);
        compare_new("R3 len1");

        // R3 length 0 acts as 1
        do_clear(0);
        base = n_res;
        for (int k = 0; k < 3; k++) send_gen(-25, 9, 3);
        idle(6);
        chk("R3 len0 strobes", n_res - base, 3);
        compare_new("R3 len0");

        // R3 mid-period length change applies to the next period
        do_clear(8);
        base = n_res;
        for (int k = 0; k < 3; k++) send_gen(12, -6, 0);
        int_len = 10'd4;
        for (int k = 0; k < 5; k++) send_gen(12, -6, 0);
        idle(6);
        chk("R3 first period still 8", n_res - base, 1);
        for (int k = 0; k < 4; k++) send_gen(12, -6, 4);
        idle(6);
        chk("R3 second period 4", n_res - base, 2);
        compare_new("R3 length change");

        // R9 clear coinciding with the period-ending sample
        do_clear(4);
        base = n_res;
        for (int k = 0; k < 3; k++) send_gen(50, 50, 0);
        samp_valid = 1'b1;
        samp_i = 8'sd50;
        samp_q = 8'sd50;
        code_in = 1'b1;
        chan_clear = 1'b1;
        @(negedge clk);
        chan_clear = 1'b0;
        samp_valid = 1'b0;
        m_clear(4);
        idle(8);
        chk("R9 no strobe after clear", n_res - base, 0);
        for (int k = 0; k < 4; k++) send_gen(-33, 17, 4);
        idle(6);
        chk("R9 fresh period strobe", n_res - base, 1);
        compare_new("R9 after clear");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule